// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block produces the timing for a small two-stage processor core. Each instruction cycle is four oscillator clocks long. The block drives four one-hot phase strobes that step through Q1, Q2, Q3 and Q4. From these phases it derives one enable for each step:

- Q1: fetch
- Q2: operand read
- Q3: execute
- Q4: write-back

It also raises a strobe that marks the last clock of every cycle.

The fetch of one instruction overlaps the execution of the instruction before it. A flag records whether the instruction now executing is real or a bubble. When the core reports a taken branch at the end of Q4, the block marks the instruction that was just fetched as invalid. The next cycle then runs as a NOP and its write-back is suppressed. A taken branch therefore costs two instruction cycles, and every other instruction costs one. Program memory, decode, the register file and the ALU are outside this block. They use the strobes to time their own work.

Top module: `qseq_top`

## Requirements
- R1: While `rst` is high, and after it falls until the next rising clock edge, `qStrobe` equals 4'b0001 (Q1), `nopFlag` is 1 and `writeEn` is 0. So the first instruction cycle after reset only fetches. A reset raised in the middle of a cycle restarts at Q1 the same way.
- R2: `qStrobe` has exactly one bit set. Bit 0 is Q1, bit 1 is Q2, bit 2 is Q3 and bit 3 is Q4. It advances one position per clock, Q1→Q2→Q3→Q4→Q1.
- R3: `cycleEnd` is high in the Q4 clock of every cycle and low in all other clocks.
- R4: `fetchEn` is high in Q1 of every cycle, bubble cycles included, and low in all other clocks.
- R5: `readEn` is high in Q2 and `execEn` is high in Q3 of every cycle, and each is low in all other clocks.
- R6: `writeEn` is high in Q4 of a cycle whose `nopFlag` is 0, and low in all other clocks.
- R7: `nopFlag` holds one value for a whole instruction cycle. It can change only at the edge from Q4 to Q1.
- R8: If `branchTaken` is 1 at the clock edge that ends Q4 of a cycle with `nopFlag` 0, the next cycle has `nopFlag` 1. Exactly one write-back is then lost.
- R9: A `branchTaken` value held only during Q1, Q2 or Q3, and low at the end of Q4, has no effect. The next cycle has `nopFlag` 0.
- R10: `branchTaken` at the end of Q4 of a bubble cycle (`nopFlag` 1) is ignored. The next cycle has `nopFlag` 0.
- R11: If `branchTaken` is 0 at the end of Q4, the next cycle has `nopFlag` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| branchTaken | input | 1 | The executing instruction takes a branch; sampled at the end of Q4 |
| qStrobe | output | 4 | One-hot phase strobes, bit 0 = Q1 through bit 3 = Q4 |
| cycleEnd | output | 1 | High in the last clock of each instruction cycle |
| fetchEn | output | 1 | Instruction fetch enable (Q1) |
| readEn | output | 1 | Operand read enable (Q2) |
| execEn | output | 1 | Execute enable (Q3) |
| writeEn | output | 1 | Write-back enable (Q4 of a valid instruction) |
| nopFlag | output | 1 | The current cycle executes a bubble |

## Verification
The assertions assume that `branchTaken` is a clean, synchronous level that is only meaningful at the Q4 edge. They place no limit on its value in other phases, so the bench can legally hold it high for whole cycles, pulse it in early phases only, or raise it during bubble cycles. The stimulus always changes `branchTaken` and `rst` on the falling clock edge, so every value is settled before the rising edge that samples it. The stimulus covers isolated branches, back-to-back branches, early-phase pulses and a reset in the middle of a cycle.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
  localparam int NUM_PHASES = 4;
  localparam int PH_FETCH   = 0;
  localparam int PH_READ    = 1;
  localparam int PH_EXEC    = 2;
  localparam int PH_WRITE   = NUM_PHASES - 1;

  typedef struct packed {
    logic [NUM_PHASES-1:0] q;
    logic                  cycleEnd;
  } seqStrobes_t;
endpackage

// File: rtl/qseq_ctrl.sv
module qseq_ctrl
  import qseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output seqStrobes_t strb
);
  logic [NUM_PHASES-1:0] phaseOh;
  logic                  cycEndQ;

  // one-hot ring, restarts at Q1; cycle-end strobe registered one phase ahead
  always_ff @(posedge clk) begin
    if (rst) begin
      phaseOh <= NUM_PHASES'(1);
      cycEndQ <= 1'b0;
    end else begin
      phaseOh <= {phaseOh[NUM_PHASES-2:0], phaseOh[NUM_PHASES-1]};
      cycEndQ <= phaseOh[NUM_PHASES-2];
    end
  end

  assign strb.q        = phaseOh;
  assign strb.cycleEnd = cycEndQ;
endmodule

// File: rtl/qseq_pipe.sv
module qseq_pipe
  import qseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  seqStrobes_t strb,
  input  logic        branchTaken,
  output logic        fetchEn,
  output logic        readEn,
  output logic        execEn,
  output logic        writeEn,
  output logic        nopFlag
);
  logic execValid;

  // the fetched slot moves into execute at the Q4 edge; a taken branch from a
  // valid instruction turns it into a bubble
  always_ff @(posedge clk) begin
    if (rst)
      execValid <= 1'b0;
    else if (strb.q[PH_WRITE])
      execValid <= ~(branchTaken & execValid);
  end

  assign fetchEn = strb.q[PH_FETCH];
  assign readEn  = strb.q[PH_READ];
  assign execEn  = strb.q[PH_EXEC];
  assign writeEn = strb.q[PH_WRITE] & execValid;
  assign nopFlag = ~execValid;
endmodule

// File: rtl/qseq_top.sv
module qseq_top
  import qseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       branchTaken,
  output logic [3:0] qStrobe,
  output logic       cycleEnd,
  output logic       fetchEn,
  output logic       readEn,
  output logic       execEn,
  output logic       writeEn,
  output logic       nopFlag
);
  seqStrobes_t strb;

  qseq_ctrl i_ctrl (
    .clk  (clk),
    .rst  (rst),
    .strb (strb)
  );

  qseq_pipe i_pipe (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .branchTaken (branchTaken),
    .fetchEn     (fetchEn),
    .readEn      (readEn),
    .execEn      (execEn),
    .writeEn     (writeEn),
    .nopFlag     (nopFlag)
  );

  assign qStrobe  = strb.q;
  assign cycleEnd = strb.cycleEnd;
endmodule

// File: rtl/qseq_checker.sv
module qseq_checker (
  input logic       clk,
  input logic       rst,
  input logic       branchTaken,
  input logic [3:0] qStrobe,
  input logic       cycleEnd,
  input logic       fetchEn,
  input logic       readEn,
  input logic       execEn,
  input logic       writeEn,
  input logic       nopFlag
);
  assert_phase_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(qStrobe) == 1);

  assert_phase_order_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> qStrobe == {$past(qStrobe[2:0]), $past(qStrobe[3])});

  assert_cycle_end_R3: assert property (@(posedge clk) disable iff (rst)
    cycleEnd == qStrobe[3]);

  assert_fetch_slot_R4: assert property (@(posedge clk) disable iff (rst)
    fetchEn == qStrobe[0]);

  assert_read_exec_slot_R5: assert property (@(posedge clk) disable iff (rst)
    (readEn == qStrobe[1]) && (execEn == qStrobe[2]));

  assert_write_slot_R6: assert property (@(posedge clk) disable iff (rst)
    writeEn |-> (qStrobe[3] && !nopFlag));

  assert_nop_steady_R7: assert property (@(posedge clk) disable iff (rst)
    !qStrobe[0] |-> $stable(nopFlag));

  assert_branch_bubble_R8: assert property (@(posedge clk) disable iff (rst)
    (qStrobe[3] && branchTaken && !nopFlag) |=> nopFlag);

  assert_no_branch_valid_R11: assert property (@(posedge clk) disable iff (rst)
    (qStrobe[3] && !branchTaken) |=> !nopFlag);

  assert_bubble_branch_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (qStrobe[3] && nopFlag) |=> !nopFlag);
endmodule

bind qseq_top qseq_checker i_qseq_checker (
  .clk         (clk),
  .rst         (rst),
  .branchTaken (branchTaken),
  .qStrobe     (qStrobe),
  .cycleEnd    (cycleEnd),
  .fetchEn     (fetchEn),
  .readEn      (readEn),
  .execEn      (execEn),
  .writeEn     (writeEn),
  .nopFlag     (nopFlag)
);

// File: tb/test_qseq_top.sv
module test_qseq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       branchTaken = 1'b0;
  logic [3:0] qStrobe;
  logic       cycleEnd, fetchEn, readEn, execEn, writeEn, nopFlag;

  int nChecks = 0;
  int nFails  = 0;
  int clkCount = 0;

  always #5 clk = ~clk;

  qseq_top i_qseq_top (
    .clk         (clk),
    .rst         (rst),
    .branchTaken (branchTaken),
    .qStrobe     (qStrobe),
    .cycleEnd    (cycleEnd),
    .fetchEn     (fetchEn),
    .readEn      (readEn),
    .execEn      (execEn),
    .writeEn     (writeEn),
    .nopFlag     (nopFlag)
  );

  // per instruction cycle: branch level held all cycle, expected bubble flag
  typedef struct packed { logic br; logic nop; } vec_t;
  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{br: 1'b0, nop: 1'b1},   // first cycle after reset (R1)
    '{br: 1'b0, nop: 1'b0},   // R11
    '{br: 1'b1, nop: 1'b0},
    '{br: 1'b0, nop: 1'b1},   // R8 bubble
    '{br: 1'b1, nop: 1'b0},
    '{br: 1'b1, nop: 1'b1},   // R8 bubble; branch here ignored (R10)
    '{br: 1'b0, nop: 1'b0},   // R10
    '{br: 1'b0, nop: 1'b0},
    '{br: 1'b1, nop: 1'b0},
    '{br: 1'b0, nop: 1'b1}    // R8 bubble
  };

  task automatic finishRun();
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Runs one instruction cycle starting at the negedge in Q1.
  // brPat[p] is driven during phase p; sampling happens at that same negedge.
  task automatic runCycle(input logic [3:0] brPat, input logic expNop, input string tag);
    for (int p = 0; p < 4; p++) begin
      branchTaken = brPat[p];
      check(qStrobe == 4'(1 << p), {tag, " R2 phase"}, qStrobe, 4'(1 << p));
      check(cycleEnd == (p == 3), {tag, " R3 cycleEnd"}, cycleEnd, (p == 3));
      check(fetchEn == (p == 0), {tag, " R4 fetchEn"}, fetchEn, (p == 0));
      check(readEn == (p == 1) && execEn == (p == 2), {tag, " R5 read/exec"},
            {readEn, execEn}, {(p == 1), (p == 2)});
      check(writeEn == (p == 3 && !expNop), {tag, " R6 writeEn"}, writeEn, (p == 3 && !expNop));
      check(nopFlag == expNop, {tag, " R7 nopFlag"}, nopFlag, expNop);
      @(negedge clk);
    end
    branchTaken = 1'b0;
  endtask

  always @(posedge clk) begin
    clkCount++;
    if (clkCount > 2000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    // R1: state held during reset
    repeat (3) @(negedge clk);
    check(qStrobe == 4'b0001, "R1 reset phase", qStrobe, 1);
    check(nopFlag == 1'b1 && writeEn == 1'b0, "R1 reset nop", {nopFlag, writeEn}, 2'b10);
    rst = 1'b0;

    // table walk
    for (int c = 0; c < NVEC; c++)
      runCycle({4{VECS[c].br}}, VECS[c].nop, $sformatf("vec%0d", c));

    // R9: branch only in Q1..Q3, low at the Q4 edge
    runCycle(4'b0111, 1'b0, "R9 early pulse");
    runCycle(4'b0000, 1'b0, "R9 after pulse");

    // R8: exactly one suppressed write-back after a single branch
    runCycle(4'b1111, 1'b0, "R8 branch");
    runCycle(4'b0000, 1'b1, "R8 bubble");
    runCycle(4'b0000, 1'b0, "R8 recovered");

    // R1: reset in the middle of a cycle (during Q3)
    @(negedge clk);
    @(negedge clk);
    check(qStrobe == 4'b0100, "R1 pre-reset Q3", qStrobe, 4'b0100);
    rst = 1'b1;
    @(negedge clk);
    check(qStrobe == 4'b0001, "R1 mid reset phase", qStrobe, 1);
    check(nopFlag == 1'b1, "R1 mid reset nop", nopFlag, 1);
    rst = 1'b0;
    runCycle(4'b1111, 1'b1, "R1 R10 post-reset");
    runCycle(4'b0000, 1'b0, "R11 post-reset");

    finishRun();
  end
endmodule